// File: doc/BRIEF.md
# SPI-Shared GPIO Port Pin Controller

This block manages a small port of general-purpose pins, two of which can be taken over by a serial peripheral interface engine. One pin carries master-out data and the other carries master-in data. Each pin has a direction bit and an output latch bit. Both are reached over a simple register bus that has one-cycle write strobes and a combinational read mux. From the SPI enable, the master/slave mode and the direction bit, the block decides two things for every pin: whether the driver is on, and where the driven value comes from.

A port-wide open-drain option changes the driver behaviour. A low value is driven actively, and a high value turns the driver off so that an external pull-up can raise the line. When the SPI engine reports a mode fault (a master being selected as a slave), the direction bits of the two SPI pins are cleared at once, which forces those pins to input. The master-in pad is always routed to the SPI engine's receive input, and the master-out pad is routed to its slave receive input. Pads are modelled as separate output-enable, output-value and input-value signals.

Top module: `spi_gpio_port`

## Requirements
- R1: After reset, every direction bit and every latch bit is 0, and every pad output-enable is low, so all pins are inputs.
- R2: A pulse on `wr_dir` loads the direction register from `wdata` on the next clock edge. With `rd_sel`=1, `rdata` returns the direction register.
- R3: A pulse on `wr_data` loads the output latch from `wdata` on the next clock edge. A general-purpose pin always drives its latch bit, whatever the SPI enable and mode.
- R4: With `rd_sel`=0, each `rdata` bit is the pin's internal output value when its driver is on. When the driver is off, the bit is the live `pad_in` bit.
- R5: While `spi_en`=1, the master-out pin's output value is `spi_mosi_out` and the master-in pin's output value is `spi_miso_out`. While `spi_en`=0, both pins take their values from the latch.
- R6: The master-out pin's driver follows its direction bit when the SPI is disabled or in master mode (`spi_master`=1). It is off in slave mode.
- R7: The master-in pin's driver follows its direction bit when the SPI is disabled or in slave mode. It is off in master mode.
- R8: On the clock edge after `mode_fault`=1, the direction bits of both SPI pins are 0, even if `wr_dir` is pulsed in the same cycle. The other direction bits take that write normally.
- R9: `spi_miso_in` always equals the master-in pad input and `spi_mosi_in` always equals the master-out pad input, regardless of direction bits and mode.
- R10: `od_req` is registered each cycle, and reset clears it to push-pull. In push-pull, `pad_oe` equals the driver enable and `pad_out` equals the value. In open-drain, `pad_out` is 0, and `pad_oe` is the driver enable ANDed with the inverted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir | input | 1 | Direction register write strobe |
| wr_data | input | 1 | Output latch write strobe |
| rd_sel | input | 1 | Read select: 1 direction, 0 port data |
| wdata | input | NUM_PINS | Write data |
| rdata | output | NUM_PINS | Read data |
| od_req | input | 1 | Open-drain mode request, port-wide |
| spi_en | input | 1 | SPI engine enabled |
| spi_master | input | 1 | SPI engine is master (1) or slave (0) |
| mode_fault | input | 1 | SPI mode fault pulse |
| spi_mosi_out | input | 1 | Master data output from SPI engine |
| spi_miso_out | input | 1 | Slave data output from SPI engine |
| spi_miso_in | output | 1 | Master receive data to SPI engine |
| spi_mosi_in | output | 1 | Slave receive data to SPI engine |
| pad_in | input | NUM_PINS | Buffered pad input values |
| pad_oe | output | NUM_PINS | Pad driver enables |
| pad_out | output | NUM_PINS | Pad driven values |

## Verification
The bench sweeps all direction patterns of a six-pin port through every combination of SPI enable, master/slave and open-drain. Each combination is paired with four mixes of pad input and engine output levels, so a driven read-back can be told apart from a live-pad read-back, and a latch source from an engine source. Running the same direction pattern under both master and slave separates the master-out direction rule from the master-in rule. Running it under both drive styles shows whether a logic one is driven or released. A separate sequence pulses the mode fault, both alone and together with a direction write, to show that the clear wins only on the two SPI pins.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    ROLE_GPIO = 2'd0,
    ROLE_MOSI = 2'd1,
    ROLE_MISO = 2'd2
  } pin_role_e;
endpackage

// File: rtl/spm_regs.sv
module spm_regs #(
  parameter int NUM_PINS = 6,
  parameter int MISO_IDX = 2,
  parameter int MOSI_IDX = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_dir,
  input  logic                wr_data,
  input  logic                mode_fault,
  input  logic                od_req,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] latch_q,
  output logic                od_q
);
  localparam logic [NUM_PINS-1:0] SPI_MASK =
    (NUM_PINS'(1) << MISO_IDX) | (NUM_PINS'(1) << MOSI_IDX);

  logic [NUM_PINS-1:0] dir_d;
  logic                dir_en;

  always_comb begin
    dir_d = dir_q;
    if (wr_dir) dir_d = wdata;
    if (mode_fault) dir_d = dir_d & ~SPI_MASK;
    dir_en = wr_dir | mode_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else if (wr_data) latch_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) od_q <= 1'b0;
    else od_q <= od_req;
  end

  // R8
  fault_clears_spi_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> ((dir_q & SPI_MASK) == '0));

  // R2
  dir_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && !mode_fault) |=> (dir_q == $past(wdata)));

  // R3
  latch_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (latch_q == $past(wdata)));
endmodule

// File: rtl/spm_pin.sv
module spm_pin #(
  parameter spm_pkg::pin_role_e ROLE = spm_pkg::ROLE_GPIO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_bit,
  input  logic latch_bit,
  input  logic spi_en,
  input  logic spi_master,
  input  logic spi_bit,
  input  logic od,
  input  logic pin_in,
  output logic pin_oe,
  output logic pin_out,
  output logic rd_bit
);
  import spm_pkg::*;

  logic drive_en;
  logic val;

  always_comb begin
    drive_en = dir_bit;
    val      = latch_bit;
    if (spi_en) begin
      case (ROLE)
        ROLE_MOSI: begin
          drive_en = spi_master & dir_bit;
          val      = spi_bit;
        end
        ROLE_MISO: begin
          drive_en = ~spi_master & dir_bit;
          val      = spi_bit;
        end
        default: begin
          drive_en = dir_bit;
          val      = latch_bit;
        end
      endcase
    end
  end

  always_comb begin
    if (od) begin
      pin_oe  = drive_en & ~val;
      pin_out = 1'b0;
    end else begin
      pin_oe  = drive_en;
      pin_out = val;
    end
    rd_bit = drive_en ? val : pin_in;
  end

  // R6
  mosi_slave_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ROLE == ROLE_MOSI && spi_en && !spi_master) |-> !pin_oe);

  // R7
  miso_master_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ROLE == ROLE_MISO && spi_en && spi_master) |-> !pin_oe);

  // R10
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od |-> !(pin_oe && pin_out));

  // R1
  no_drive_without_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_bit |-> !pin_oe);
endmodule

// File: rtl/spi_gpio_port.sv
module spi_gpio_port #(
  parameter int NUM_PINS = 6,
  parameter int MISO_IDX = 2,
  parameter int MOSI_IDX = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_dir,
  input  logic                wr_data,
  input  logic                rd_sel,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] rdata,
  input  logic                od_req,
  input  logic                spi_en,
  input  logic                spi_master,
  input  logic                mode_fault,
  input  logic                spi_mosi_out,
  input  logic                spi_miso_out,
  output logic                spi_miso_in,
  output logic                spi_mosi_in,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);
  logic [1:0]          rst_sync_q;
  logic                rst_sync_n;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] latch_q;
  logic                od_q;
  logic [NUM_PINS-1:0] rd_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  spm_regs #(
    .NUM_PINS(NUM_PINS), .MISO_IDX(MISO_IDX), .MOSI_IDX(MOSI_IDX)
  ) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_dir(wr_dir), .wr_data(wr_data),
    .mode_fault(mode_fault), .od_req(od_req), .wdata(wdata),
    .dir_q(dir_q), .latch_q(latch_q), .od_q(od_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam spm_pkg::pin_role_e PIN_ROLE =
      (i == MOSI_IDX) ? spm_pkg::ROLE_MOSI :
      (i == MISO_IDX) ? spm_pkg::ROLE_MISO : spm_pkg::ROLE_GPIO;
    logic eng_bit;
    assign eng_bit = (PIN_ROLE == spm_pkg::ROLE_MOSI) ? spi_mosi_out : spi_miso_out;

    spm_pin #(.ROLE(PIN_ROLE)) i_pin (
      .clk(clk), .rst_n(rst_sync_n), .dir_bit(dir_q[i]), .latch_bit(latch_q[i]),
      .spi_en(spi_en), .spi_master(spi_master), .spi_bit(eng_bit), .od(od_q),
      .pin_in(pad_in[i]), .pin_oe(pad_oe[i]), .pin_out(pad_out[i]),
      .rd_bit(rd_vec[i])
    );
  end

  assign rdata       = rd_sel ? dir_q : rd_vec;
  assign spi_miso_in = pad_in[MISO_IDX];
  assign spi_mosi_in = pad_in[MOSI_IDX];

  // R10
  port_od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    od_q |-> ((pad_oe & pad_out) == '0));

  // R8
  fault_releases_spi_pads_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_fault |=> (!pad_oe[MISO_IDX] && !pad_oe[MOSI_IDX]));
endmodule

// File: tb/test_spi_gpio_port.sv
module test_spi_gpio_port;
  localparam int N    = 6;
  localparam int MISO = 2;
  localparam int MOSI = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_dir, wr_data, rd_sel, od_req, spi_en, spi_master, mode_fault;
  logic         spi_mosi_out, spi_miso_out;
  logic [N-1:0] wdata, rdata, pad_in, pad_oe, pad_out;
  logic         spi_miso_in, spi_mosi_in;
  int           tests = 0;
  int           fails = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  spi_gpio_port #(.NUM_PINS(N), .MISO_IDX(MISO), .MOSI_IDX(MOSI)) i_spi_gpio_port (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_data(wr_data), .rd_sel(rd_sel),
    .wdata(wdata), .rdata(rdata), .od_req(od_req), .spi_en(spi_en),
    .spi_master(spi_master), .mode_fault(mode_fault), .spi_mosi_out(spi_mosi_out),
    .spi_miso_out(spi_miso_out), .spi_miso_in(spi_miso_in), .spi_mosi_in(spi_mosi_in),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr_reg(bit is_dir, logic [N-1:0] v);
    @(negedge clk);
    wr_dir  = is_dir;
    wr_data = !is_dir;
    wdata   = v;
    @(negedge clk);
    wr_dir  = 1'b0;
    wr_data = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] e_oe, e_out, e_rd, latch;
    rst_n = 1'b0; wr_dir = 0; wr_data = 0; rd_sel = 0; od_req = 0; spi_en = 0;
    spi_master = 0; mode_fault = 0; spi_mosi_out = 0; spi_miso_out = 0;
    wdata = '0; pad_in = 6'b101101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd_sel = 1'b1; #1;
    check("R1 dir reset", rdata, '0);
    rd_sel = 1'b0; #1;
    check("R1 pads read live", rdata, pad_in);
    check("R1 oe low", pad_oe, '0);
    spi_en = 0; od_req = 0;
    wr_reg(1'b1, '1); #1;
    check("R1 latch reset", pad_out, '0);

    // Sweep: mode bits {od, spi_master, spi_en}, all directions, four pad mixes
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      spi_en = m[0]; spi_master = m[1]; od_req = m[2];
      for (int d = 0; d < 64; d++) begin
        latch = 6'(d) ^ 6'b101010;
        wr_reg(1'b1, 6'(d));
        wr_reg(1'b0, latch);
        for (int p = 0; p < 4; p++) begin
          @(negedge clk);
          pad_in       = p[0] ? 6'b110011 : 6'b001100;
          spi_mosi_out = p[1];
          spi_miso_out = !p[1];
          rd_sel       = 1'b0;
          #1;
          for (int i = 0; i < N; i++) begin
            logic drv, val;
            drv = d[i];
            val = latch[i];
            if (m[0] && i == MOSI) begin drv = m[1] & d[i];  val = spi_mosi_out; end // R5 R6
            if (m[0] && i == MISO) begin drv = !m[1] & d[i]; val = spi_miso_out; end // R5 R7
            e_oe[i]  = m[2] ? (drv & !val) : drv;                                   // R10
            e_out[i] = m[2] ? 1'b0 : val;
            e_rd[i]  = drv ? val : pad_in[i];                                       // R4
          end
          check("R3 R5 R6 R7 R10 pad_oe", pad_oe, e_oe);
          check("R3 R5 R10 pad_out", pad_out, e_out);
          check("R4 port read", rdata, e_rd);
          check("R9 spi inputs", N'({spi_miso_in, spi_mosi_in}),
                N'({pad_in[MISO], pad_in[MOSI]}));
          rd_sel = 1'b1; #1;
          check("R2 dir read", rdata, 6'(d));
        end
      end
    end

    // R8: mode fault alone, then with a simultaneous direction write
    @(negedge clk);
    spi_en = 1'b0; od_req = 1'b0; rd_sel = 1'b1;
    wr_reg(1'b1, '1);
    @(negedge clk); mode_fault = 1'b1;
    @(negedge clk); mode_fault = 1'b0; #1;
    check("R8 fault alone", rdata, 6'b110011);
    wr_reg(1'b1, 6'b000000);
    @(negedge clk);
    mode_fault = 1'b1; wr_dir = 1'b1; wdata = '1;
    @(negedge clk);
    mode_fault = 1'b0; wr_dir = 1'b0; #1;
    check("R8 fault beats write", rdata, 6'b110011);
    check("R8 spi pads released", pad_oe & 6'b001100, '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule